// File: doc/BRIEF.md
# Virtual Segment Classifier

This block sits in front of the translation lookaside buffer. For each virtual address it decides whether the address lies in one of the two kernel windows that skip translation. When it does, the block produces the physical address directly. It also works out cacheability from the address bits alone, and it decides whether the access must raise an address error.

The classifier is purely combinational, so every output follows its inputs within the same cycle. The core presents four things: the virtual address, the kind of access (instruction fetch or data), the privilege level, and an alignment hint from its load/store unit. For data accesses it also presents the access width. The block answers with a bypass flag, the direct physical address, an uncacheable flag and a fault code. When a fault is raised, the offending virtual address is also reported. The translation lookup for mapped addresses and the routing of exceptions happen downstream.

Top module: `vseg_classifier`

## Requirements
- R1: An address whose bits 31:29 are 3'b100 (0x80000000 to 0x9FFFFFFF, the cached kernel window) sets `bypass_o`, and `paddr_o` is the address with bits 31:29 cleared.
- R2: An address whose bits 31:29 are 3'b101 (0xA0000000 to 0xBFFFFFFF, the uncached kernel window) sets `bypass_o`, and `paddr_o` is the address with bits 31:29 cleared.
- R3: Every other address is mapped: `bypass_o` is 0 and `paddr_o` is 0.
- R4: `uncached_o` is 1 exactly when bits 31 and 29 of the address are both 1, i.e. (vaddr & 0xA0000000) == 0xA0000000, whatever the window.
- R5: An access to the cached kernel window while `kernel_i` is 0 raises an address error.
- R6: A misaligned access to the cached kernel window raises an address error even when `kernel_i` is 1.
- R7: An access to the uncached kernel window never raises an address error, whatever the privilege or alignment.
- R8: In a mapped address, a misaligned access raises an address error, and an aligned one raises none.
- R9: An access is misaligned when `misalign_i` is 1. For data accesses only, it is also misaligned when vaddr & (2^size_i - 1) is nonzero, where `size_i` codes the width as 0=1, 1=2, 2=4 and 3=8 bytes. Fetches ignore `size_i`.
- R10: `fault_o` is 2'd0 for no fault, 2'd1 for an address error on a fetch, and 2'd2 for an address error on a data access (load or store alike). The value 2'd3 never appears.
- R11: `bad_vaddr_o` equals the input address whenever `fault_o` is nonzero, and is 0 otherwise.
- R12: All outputs reflect the present inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr_i | input | 32 | Virtual address of the access |
| fetch_i | input | 1 | 1 for an instruction fetch, 0 for a data access |
| kernel_i | input | 1 | 1 when the core runs in kernel mode |
| misalign_i | input | 1 | Misalignment already detected by the requester |
| size_i | input | 2 | Data access width code (0=1, 1=2, 2=4, 3=8 bytes) |
| bypass_o | output | 1 | Address skips translation |
| paddr_o | output | 32 | Direct physical address when bypassing, else 0 |
| uncached_o | output | 1 | Access must not be cached |
| fault_o | output | 2 | Address error code: 0 none, 1 fetch, 2 data |
| bad_vaddr_o | output | 32 | Faulting virtual address, 0 when no fault |

## Verification
Some properties are checked by the assertions on every input change. In bypass mode the upper three physical bits are always zero, and a mapped address never carries a physical address. The uncacheable flag never appears unless bits 31 and 29 are set. The uncached window never faults, an unprivileged access to the cached window always faults, the fault code stays legal, and a reported bad address always matches the fault. Two behaviours can only be shown by the bench's address and width patterns: that fetch and data select different fault codes, and that the width-based alignment rule applies to data only. The same holds for the exact window edges (0x7FFFFFFF, 0xC0000000, 0xE0000000), which the vector table covers.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEL_W   = 3;
  localparam int SIZE_W  = 2;
  localparam int LOW_W   = 3;
  localparam int FAULT_W = 2;

  typedef enum logic [1:0] {
    SEG_MAPPED    = 2'd0,
    SEG_KCACHED   = 2'd1,
    SEG_KUNCACHED = 2'd2
  } seg_e;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE  = 2'd0,
    FLT_FETCH = 2'd1,
    FLT_DATA  = 2'd2
  } fault_e;

  function automatic seg_e seg_of(input logic [ADDR_W-1:0] va);
    unique case (va[ADDR_W-1 -: SEL_W])
      3'b100:  return SEG_KCACHED;
      3'b101:  return SEG_KUNCACHED;
      default: return SEG_MAPPED;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] direct_pa(input logic [ADDR_W-1:0] va);
    logic [ADDR_W-1:0] r;
    r = va;
    r[ADDR_W-1 -: SEL_W] = '0;
    return r;
  endfunction

  function automatic logic uncached_of(input logic [ADDR_W-1:0] va);
    return va[ADDR_W-1] & va[ADDR_W-3];
  endfunction

  function automatic logic [LOW_W-1:0] width_mask(input logic [SIZE_W-1:0] sz);
    logic [LOW_W:0] one_hot;
    one_hot = (LOW_W+1)'(1) << sz;
    return LOW_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
(
  input  logic [ADDR_W-1:0] vaddr_i,
  output seg_e              seg_o,
  output logic              bypass_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              uncached_o
);
  always_comb begin
    seg_o      = seg_of(vaddr_i);
    bypass_o   = (seg_o != SEG_MAPPED);
    paddr_o    = bypass_o ? direct_pa(vaddr_i) : '0;
    uncached_o = uncached_of(vaddr_i);

    a_r1_bypass_top_bits_clear: assert (!bypass_o || paddr_o[ADDR_W-1 -: SEL_W] == '0);
    a_r3_mapped_no_paddr: assert (bypass_o || paddr_o == '0);
    a_r4_uncached_needs_bits: assert (!uncached_o || (vaddr_i[ADDR_W-1] && vaddr_i[ADDR_W-3]));
  end
endmodule

// File: rtl/vseg_align.sv
module vseg_align
  import vseg_pkg::*;
(
  input  logic [LOW_W-1:0]  low_i,
  input  logic              fetch_i,
  input  logic              misalign_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              misaligned_o
);
  logic width_bad;
  always_comb begin
    width_bad    = !fetch_i && ((low_i & width_mask(size_i)) != '0);
    misaligned_o = misalign_i || width_bad;

    a_r9_flag_forces_misaligned: assert (!misalign_i || misaligned_o);
    a_r9_byte_data_never_width_bad: assert (fetch_i || size_i != 2'd0 || misaligned_o == misalign_i);
  end
endmodule

// File: rtl/vseg_fault.sv
module vseg_fault
  import vseg_pkg::*;
(
  input  seg_e              seg_i,
  input  logic              fetch_i,
  input  logic              kernel_i,
  input  logic              misaligned_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output fault_e            fault_o,
  output logic [ADDR_W-1:0] bad_vaddr_o
);
  logic raise;
  always_comb begin
    unique case (seg_i)
      SEG_KCACHED:   raise = !kernel_i || misaligned_i;
      SEG_KUNCACHED: raise = 1'b0;
      default:       raise = misaligned_i;
    endcase
    fault_o     = !raise ? FLT_NONE : (fetch_i ? FLT_FETCH : FLT_DATA);
    bad_vaddr_o = raise ? vaddr_i : '0;

    a_r7_uncached_window_no_fault: assert (seg_i != SEG_KUNCACHED || fault_o == FLT_NONE);
    a_r5_user_in_kernel_window: assert (seg_i != SEG_KCACHED || kernel_i || fault_o != FLT_NONE);
    a_r10_code_legal: assert (fault_o != 2'd3);
    a_r11_bad_matches_fault: assert ((fault_o == FLT_NONE) ? (bad_vaddr_o == '0) : (bad_vaddr_o == vaddr_i));
  end
endmodule

// File: rtl/vseg_classifier.sv
module vseg_classifier
  import vseg_pkg::*;
(
  input  logic [31:0] vaddr_i,
  input  logic        fetch_i,
  input  logic        kernel_i,
  input  logic        misalign_i,
  input  logic [1:0]  size_i,
  output logic        bypass_o,
  output logic [31:0] paddr_o,
  output logic        uncached_o,
  output logic [1:0]  fault_o,
  output logic [31:0] bad_vaddr_o
);
  seg_e   seg_w;
  logic   misaligned_w;
  fault_e fault_w;

  vseg_decode u_decode (
    .vaddr_i    (vaddr_i),
    .seg_o      (seg_w),
    .bypass_o   (bypass_o),
    .paddr_o    (paddr_o),
    .uncached_o (uncached_o)
  );

  vseg_align u_align (
    .low_i        (vaddr_i[LOW_W-1:0]),
    .fetch_i      (fetch_i),
    .misalign_i   (misalign_i),
    .size_i       (size_i),
    .misaligned_o (misaligned_w)
  );

  vseg_fault u_fault (
    .seg_i        (seg_w),
    .fetch_i      (fetch_i),
    .kernel_i     (kernel_i),
    .misaligned_i (misaligned_w),
    .vaddr_i      (vaddr_i),
    .fault_o      (fault_w),
    .bad_vaddr_o  (bad_vaddr_o)
  );

  assign fault_o = fault_w;
endmodule

// File: tb/tb_vseg_classifier.sv
module tb_vseg_classifier;
  typedef struct packed {
    logic [31:0] va;
    logic        f;
    logic        k;
    logic        m;
    logic [1:0]  sz;
    logic        byp;
    logic [31:0] pa;
    logic        unc;
    logic [1:0]  flt;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{32'h80001000, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 32'h00001000, 1'b0, 2'd0}, // R1
    '{32'h9FFFFFFC, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 32'h1FFFFFFC, 1'b0, 2'd0}, // R1
    '{32'h80000010, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 32'h00000010, 1'b0, 2'd2}, // R5 data
    '{32'h80000010, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 32'h00000010, 1'b0, 2'd1}, // R5 fetch
    '{32'h80000002, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 32'h00000002, 1'b0, 2'd2}, // R6 width
    '{32'h80000002, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 32'h00000002, 1'b0, 2'd0}, // R9 fetch ignores size
    '{32'h80000004, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 32'h00000004, 1'b0, 2'd1}, // R6 flag
    '{32'hA0000123, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 32'h00000123, 1'b1, 2'd0}, // R2 R7
    '{32'hBFFFFFFF, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 32'h1FFFFFFF, 1'b1, 2'd0}, // R2 R7
    '{32'h00400000, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 32'h00000000, 1'b0, 2'd0}, // R3 R8
    '{32'h00400004, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 32'h00000000, 1'b0, 2'd2}, // R8 R9
    '{32'h00400006, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 32'h00000000, 1'b0, 2'd0}, // R9 half
    '{32'h7FFFFFFF, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 32'h00000000, 1'b0, 2'd1}, // R8 edge
    '{32'hC0000000, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 32'h00000000, 1'b0, 2'd0}, // R3 edge
    '{32'hE0000008, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 32'h00000000, 1'b1, 2'd0}, // R4
    '{32'h20000000, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 32'h00000000, 1'b0, 2'd0}, // R4
    '{32'h00400001, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h00000000, 1'b0, 2'd0}  // R9 byte
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr;
  logic        fetch, kernel, mis;
  logic [1:0]  size;
  logic        bypass, uncached;
  logic [31:0] paddr, bad;
  logic [1:0]  fault;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  vseg_classifier dut (
    .vaddr_i     (vaddr),
    .fetch_i     (fetch),
    .kernel_i    (kernel),
    .misalign_i  (mis),
    .size_i      (size),
    .bypass_o    (bypass),
    .paddr_o     (paddr),
    .uncached_o  (uncached),
    .fault_o     (fault),
    .bad_vaddr_o (bad)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (vaddr %h)", req, what, act, exp, vaddr);
    end
  endtask

  task automatic apply_check(input vec_t v, input string req);
    @(posedge clk);
    #1;
    vaddr = v.va; fetch = v.f; kernel = v.k; mis = v.m; size = v.sz;
    #0.5; // R12: sampled in the same cycle, no edge in between
    check(req, "bypass",   32'(bypass),   32'(v.byp));
    check(req, "paddr",    paddr,         v.pa);
    check(req, "uncached", 32'(uncached), 32'(v.unc));
    check(req, "fault",    32'(fault),    32'(v.flt));
    check(req, "bad_vaddr", bad, (v.flt != 2'd0) ? v.va : 32'h0);
  endtask

  initial begin
    vaddr = '0; fetch = 1'b0; kernel = 1'b0; mis = 1'b0; size = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R3", "reset bypass", 32'(bypass), 32'h0);
    check("R3", "reset paddr",  paddr,       32'h0);
    check("R11", "reset fault", 32'(fault),  32'h0);
    check("R11", "reset bad",   bad,         32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply_check(TBL[i], "R1-tab");

    // directed corners
    apply_check('{32'h80000000, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 32'h00000000, 1'b0, 2'd0}, "R1");
    apply_check('{32'hA0000000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h00000000, 1'b1, 2'd0}, "R2");
    apply_check('{32'h9FFFFFFF, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 32'h1FFFFFFF, 1'b0, 2'd2}, "R6");
    apply_check('{32'hFFFFFFF8, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 32'h00000000, 1'b1, 2'd0}, "R4");
    apply_check('{32'h00001002, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 32'h00000000, 1'b0, 2'd2}, "R10");
    apply_check('{32'h00001002, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 32'h00000000, 1'b0, 2'd1}, "R10");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule